// File: doc/BRIEF.md
# Tapped segmentable serial shift register

This block is a 64-stage serial shift register with taps at the last stage of each 16-stage segment. A single mode input chooses between two ways of working. In chained mode all stages form one long chain. Each tap drives the bit held at the end of its segment. In split mode the tap drivers switch off and the register falls apart into four 16-stage segments. The first segment still takes the serial input. Each later segment takes its head bit from the tap input of the segment before it.

Each bidirectional tap is modelled as three signals: a read bus, a write bus and a shared output enable. A pad ring or a neighbouring block combines them into the real pin. The stage-64 tap can only drive, so there are three tap inputs and four tap outputs. A synchronous reset clears every stage, so the block starts from a known state.

Top module: `seg_shift_reg`

## Requirements
- R1: On every rising clock edge when reset is low, `ser_in` is stored in stage 1 in either mode.
- R2: While `split` is 0, `tap_oe` is 1 and `tap_out[k]` equals stage 16·(k+1) for k = 0..3. Bit 3 shows stage 64.
- R3: While `split` is 0, each edge moves every stage into the next one. A bit applied on `ser_in` shows on `tap_out[3]` after exactly 64 edges.
- R4: While `split` is 1, `tap_oe` is 0 and `tap_out` reads all zeros.
- R5: While `split` is 1, an edge stores `tap_in[k]` in stage 16·(k+1)+1 for k = 0..2. That bit reaches the end of its segment after exactly 16 edges.
- R6: While `split` is 0, `tap_in` has no effect on any stage.
- R7: `tap_out` and `tap_oe` follow `split` at once, with no clock edge. Stored bits are not changed by a mode change alone.
- R8: An edge with `rst` high clears all 64 stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all stages |
| split | input | 1 | 1 = four independent segments with taps released, 0 = one chain with taps driven |
| ser_in | input | 1 | Serial data into stage 1 |
| tap_in | input | 3 | Head data for segments 2..4, used only in split mode |
| tap_out | output | 4 | End-of-segment bits, bit k = stage 16·(k+1), zero when released |
| tap_oe | output | 1 | Tap driver enable |

## Verification
The bench uses the default geometry: four segments of 16 stages. It can therefore fill the whole chain with a known marker in 64 edges and time its arrival at the last tap. It can also time a 16-edge walk through one segment. A mixed vector table switches the mode in the middle of a stream, and a 64-entry reference model is compared with all four taps on every cycle. Split-mode loads become visible once the bench returns to chained mode.

// File: rtl/seg_shift_reg.sv
module seg_shift_reg #(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               split,
  input  logic               ser_in,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic               tap_oe
);
  localparam int DEPTH = SEG_LEN * NUM_SEG;

  logic [DEPTH-1:0] q;
  logic [NUM_SEG-1:0] ends;

  assign tap_oe = ~split;

  genvar s;
  generate
    for (s = 0; s < NUM_SEG; s++) begin : g_seg
      logic head_d;
      if (s == 0) begin : g_first
        assign head_d = ser_in;
      end else begin : g_rest
        assign head_d = split ? tap_in[s-1] : q[s*SEG_LEN-1];
      end
      always_ff @(posedge clk) begin
        if (rst) q[s*SEG_LEN +: SEG_LEN] <= '0;
        else     q[s*SEG_LEN +: SEG_LEN] <= {q[s*SEG_LEN +: SEG_LEN-1], head_d};
      end
      assign ends[s] = q[(s+1)*SEG_LEN-1];
    end
  endgenerate

  assign tap_out = tap_oe ? ends : '0;

  // R1
  stage1_load_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> q[0] == $past(ser_in));

  // R3
  chain_link_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !split) |=> q[SEG_LEN] == $past(q[SEG_LEN-1]));

  // R5
  split_head_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && split) |=> q[SEG_LEN] == $past(tap_in[0]));

  // R4
  released_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    split |-> (tap_out == '0 && !tap_oe));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: tb/seg_shift_reg_bench.sv
module seg_shift_reg_bench;
  logic clk = 0, rst = 1, split = 0, ser_in = 0;
  logic [2:0] tap_in = '0;
  logic [3:0] tap_out;
  logic tap_oe;
  logic [63:0] rq = '0;
  int n_cmp = 0, n_bad = 0;

  seg_shift_reg u_seg_shift_reg (.clk(clk), .rst(rst), .split(split), .ser_in(ser_in),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe));

  always #10 clk = ~clk;

  // {split, ser_in, tap_in[2:0]}
  localparam logic [4:0] VEC [0:15] = '{
    5'b01000, 5'b00000, 5'b01111, 5'b11101, 5'b10010, 5'b11111, 5'b00101, 5'b01010,
    5'b10111, 5'b10000, 5'b11011, 5'b01100, 5'b00011, 5'b11000, 5'b10101, 5'b01001};

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] exp_taps();
    return split ? 4'b0 : {rq[63], rq[47], rq[31], rq[15]};
  endfunction

  task automatic compare(string tag);
    check({tag, " taps"}, {28'b0, tap_out}, {28'b0, exp_taps()});
    check({tag, " oe"}, {31'b0, tap_oe}, {31'b0, !split});
  endtask

  task automatic step();
    logic [63:0] nq;
    @(posedge clk);
    if (rst) nq = '0;
    else begin
      nq[0] = ser_in;
      for (int i = 1; i < 64; i++)
        nq[i] = (split && (i % 16 == 0)) ? tap_in[i/16-1] : rq[i-1];
    end
    rq = nq;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin #3_000_000; n_bad++; n_cmp++; $display("FAIL watchdog expired"); end
    join_none

    @(negedge clk); step();
    rst = 0;
    compare("R8 reset");

    // Mixed stream: mode switches mid-stream (R1 R2 R4 R5 R6)
    for (int p = 0; p < 8; p++)
      for (int v = 0; v < 16; v++) begin
        {split, ser_in, tap_in} = VEC[(v + p * 5) % 16];
        #1 compare("R7 mode follow");
        step();
        compare("R1 R2 R5 R6 stream");
      end

    // R7: mode change alone keeps contents
    split = 0; #1 compare("R7 chained view");
    split = 1; #1 compare("R7 released");
    split = 0; #1 compare("R7 restored");

    // R8: reset clears a populated chain
    rst = 1; step(); rst = 0;
    check("R8 cleared", {28'b0, tap_out}, 32'h0);

    // R3: 64-edge latency in chained mode, tap_in toggling (R6)
    split = 0; ser_in = 1; tap_in = 3'b111;
    step(); ser_in = 0;
    for (int e = 2; e <= 64; e++) begin
      tap_in = ~tap_in;
      step();
      if (e == 63) check("R3 not early", {31'b0, tap_out[3]}, 32'h0);
    end
    check("R3 latency 64", {31'b0, tap_out[3]}, 32'h1);
    compare("R6 tap_in ignored");

    // R5: 16-edge walk within segment 2
    rst = 1; step(); rst = 0;
    split = 1; ser_in = 0; tap_in = 3'b001;
    step(); tap_in = 3'b000;
    for (int e = 2; e <= 15; e++) step();
    split = 0; #1;
    check("R5 not early", {28'b0, tap_out}, 32'h0);
    split = 1; step(); split = 0; #1;
    check("R5 latency 16", {28'b0, tap_out}, 32'h2);
    compare("R5 ref");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule